// File: doc/BRIEF.md
# Two-Edge Delay Line Fine-Time Decoder

This block turns one snapshot of a tapped delay line into a fine-time code. The snapshot is taken on the system clock edge, so that edge serves as the stop of the measurement. Each hit sends two transitions into the same line: a rising edge first, then a falling edge behind it. In a clean snapshot the taps that lie between the two edges read one and all other taps read zero. Tap 0 is the end where the line is entered, and tap TAPS-1 is the far end.

The decoder registers the snapshot once. It then finds the lowest set tap and the highest set tap with two priority searches, and adds the two indices into a code one bit wider than a single index. The code counts backwards: a larger value means the edges travelled further, so less time passed between the hit and the stop edge. A snapshot in which one edge overtook the other, in which the pattern ran off the far end, or in which the trailing edge never entered the line, is reported as an error and is not decoded.

Top module: `twu_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `hit_valid`, `pattern_err` and `fine_code` are all zero.
- R2: A snapshot presented with `tap_valid` high before clock edge k produces its result after edge k+1. Both outputs are still low after edge k, and each strobe yields exactly one cycle of result.
- R3: When `tap_valid` is low the tap vector is ignored: two edges later `hit_valid`, `pattern_err` and `fine_code` are zero.
- R4: A strobed snapshot with every tap zero gives no hit and no error.
- R5: A strobed snapshot whose ones form a single run from tap L to tap H, with 1 <= L <= H <= TAPS-2, gives `hit_valid` = 1 and `fine_code` = L + H.
- R6: The code does not wrap at the far end of the line: with TAPS = 128, L = H = 126 gives 252 and L = 1, H = 126 gives 127.
- R7: A strobed snapshot with tap TAPS-1 set (the pattern ran off the far end) raises `pattern_err` and leaves `hit_valid` low.
- R8: A strobed snapshot with two or more separate runs of ones (one edge overtook the other) raises `pattern_err` and leaves `hit_valid` low.
- R9: A strobed snapshot with tap 0 set, where fewer than two edges lie inside the line, raises `pattern_err` and leaves `hit_valid` low.
- R10: `hit_valid` and `pattern_err` are never high together, and `fine_code` is zero whenever `hit_valid` is low.
- R11: Strobes on consecutive cycles give results on consecutive cycles, in the same order and each with the same two-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; its rising edge is the stop edge that samples the line |
| rst | input | 1 | Synchronous reset, active high |
| tap_valid | input | 1 | The tap vector holds a hit snapshot this cycle |
| tap_vec | input | TAPS | Sampled delay line taps, bit 0 at the entry end |
| fine_code | output | $clog2(TAPS)+1 | Sum of the two edge indices, counting backwards; zero when no hit |
| hit_valid | output | 1 | A clean two-edge pattern was decoded |
| pattern_err | output | 1 | The snapshot showed activity but no clean two-edge pattern |

## Verification
A wrong bit in the registered snapshot or in an edge search appears after exactly two edges, as a code that differs from L + H or as a wrongly raised error. An error in the transition count flips a clean run into an error, or lets a split run through as a hit, in the very next result. A stuck capture register either moves results by a cycle or repeats them, which the back-to-back stream and the idle checks catch one cycle after the expected slot.

// File: rtl/twu_pkg.sv
package twu_pkg;

   // Class of a registered snapshot
   typedef enum logic [1:0] {
      SNAP_IDLE = 2'd0,
      SNAP_GOOD = 2'd1,
      SNAP_BAD  = 2'd2
   } snap_class_t;

endpackage

// File: rtl/twu_capture.sv
module twu_capture #(
   parameter int TAPS = 128
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [TAPS-1:0] in_taps,
   output logic            s_valid,
   output logic [TAPS-1:0] s_taps
);

   always_ff @(posedge clk) begin
      if (rst) begin
         s_valid <= 1'b0;
         s_taps  <= '0;
      end else begin
         s_valid <= in_valid;
         s_taps  <= in_valid ? in_taps : '0;
      end
   end

   // R2: a registered snapshot only follows a strobe
   a_r2_capture_follows_strobe: assert property (@(posedge clk) disable iff (rst)
      s_valid |-> $past(in_valid));

   // R3: unstrobed taps never reach the decoder
   a_r3_idle_taps_cleared: assert property (@(posedge clk) disable iff (rst)
      !s_valid |-> (s_taps == '0));

endmodule

// File: rtl/twu_edge_find.sv
module twu_edge_find #(
   parameter int TAPS     = 128,
   parameter bit FROM_TOP = 1'b0,
   localparam int IDX_W   = $clog2(TAPS)
) (
   input  logic [TAPS-1:0]  vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   assign found = |vec;

   generate
      if (FROM_TOP) begin : g_highest
         always_comb begin
            idx = '0;
            for (int i = 0; i < TAPS; i++) begin
               if (vec[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_lowest
         always_comb begin
            idx = '0;
            for (int i = TAPS - 1; i >= 0; i--) begin
               if (vec[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate

   // R5: a reported edge index always points at a set tap
   always_comb begin
      if (found) begin
         a_r5_edge_on_set_tap: assert (vec[idx]);
      end
   end

endmodule

// File: rtl/twu_transition_count.sv
module twu_transition_count #(
   parameter int TAPS    = 128,
   localparam int CNT_W  = $clog2(TAPS) + 1
) (
   input  logic [TAPS-1:0]  vec,
   output logic [CNT_W-1:0] count
);

   logic [TAPS-2:0] diff;

   genvar g;
   generate
      for (g = 0; g < TAPS - 1; g++) begin : g_diff
         assign diff[g] = vec[g] ^ vec[g+1];
      end
   endgenerate

   always_comb begin
      count = '0;
      for (int i = 0; i < TAPS - 1; i++) begin
         count = count + CNT_W'(diff[i]);
      end
   end

endmodule

// File: rtl/twu_decoder.sv
module twu_decoder #(
   parameter int TAPS     = 128,
   localparam int IDX_W   = $clog2(TAPS),
   localparam int CODE_W  = IDX_W + 1,
   localparam int CNT_W   = IDX_W + 1,
   localparam int CODE_MAX = 2 * TAPS - 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tap_valid,
   input  logic [TAPS-1:0]   tap_vec,
   output logic [CODE_W-1:0] fine_code,
   output logic              hit_valid,
   output logic              pattern_err
);
   import twu_pkg::*;

   generate
      if (TAPS < 4) begin : g_bad_taps
         $error("twu_decoder: TAPS must be at least 4");
      end
   endgenerate

   logic              snap_valid;
   logic [TAPS-1:0]   snap_taps;
   logic              lo_found, hi_found;
   logic [IDX_W-1:0]  lo_idx, hi_idx;
   logic [CNT_W-1:0]  edge_cnt;
   logic [CODE_W-1:0] code_sum;
   snap_class_t       snap_class;

   twu_capture #(.TAPS(TAPS)) u_capture (
      .clk      (clk),
      .rst      (rst),
      .in_valid (tap_valid),
      .in_taps  (tap_vec),
      .s_valid  (snap_valid),
      .s_taps   (snap_taps)
   );

   twu_edge_find #(.TAPS(TAPS), .FROM_TOP(1'b0)) u_trail (
      .vec   (snap_taps),
      .found (lo_found),
      .idx   (lo_idx)
   );

   twu_edge_find #(.TAPS(TAPS), .FROM_TOP(1'b1)) u_lead (
      .vec   (snap_taps),
      .found (hi_found),
      .idx   (hi_idx)
   );

   twu_transition_count #(.TAPS(TAPS)) u_count (
      .vec   (snap_taps),
      .count (edge_cnt)
   );

   assign code_sum = {1'b0, lo_idx} + {1'b0, hi_idx};

   always_comb begin
      if (!snap_valid || !(lo_found && hi_found)) begin
         snap_class = SNAP_IDLE;
      end else if (edge_cnt == CNT_W'(2) && !snap_taps[0]) begin
         snap_class = SNAP_GOOD;
      end else begin
         snap_class = SNAP_BAD;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hit_valid   <= 1'b0;
         pattern_err <= 1'b0;
         fine_code   <= '0;
      end else begin
         hit_valid   <= (snap_class == SNAP_GOOD);
         pattern_err <= (snap_class == SNAP_BAD);
         fine_code   <= (snap_class == SNAP_GOOD) ? code_sum : '0;
      end
   end

   // R10: hit and error are exclusive
   a_r10_hit_err_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(hit_valid && pattern_err));

   // R10: code is cleared without a hit
   a_r10_code_zero_idle: assert property (@(posedge clk) disable iff (rst)
      !hit_valid |-> (fine_code == '0));

   // R2: every result stems from a registered snapshot one cycle earlier
   a_r2_result_after_snapshot: assert property (@(posedge clk) disable iff (rst)
      (hit_valid || pattern_err) |-> $past(snap_valid));

   // R6: a decoded code stays inside the reachable range
   a_r6_code_in_range: assert property (@(posedge clk) disable iff (rst)
      hit_valid |-> (int'(fine_code) >= 2 && int'(fine_code) <= CODE_MAX));

   // R8: an error needs tap activity in the snapshot
   a_r8_err_needs_activity: assert property (@(posedge clk) disable iff (rst)
      pattern_err |-> $past(snap_valid && (snap_taps != '0)));

endmodule

// File: tb/twu_decoder_tb.sv
`timescale 1ns/1ps
module twu_decoder_tb;

   localparam int TAPS   = 128;
   localparam int CODE_W = $clog2(TAPS) + 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              tap_valid = 1'b0;
   logic [TAPS-1:0]   tap_vec = '0;
   logic [CODE_W-1:0] fine_code;
   logic              hit_valid;
   logic              pattern_err;

   int n_checks = 0;
   int n_bad    = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   twu_decoder #(.TAPS(TAPS)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .tap_valid   (tap_valid),
      .tap_vec     (tap_vec),
      .fine_code   (fine_code),
      .hit_valid   (hit_valid),
      .pattern_err (pattern_err)
   );

   function automatic logic [TAPS-1:0] run(input int lo, input int hi);
      logic [TAPS-1:0] v = '0;
      for (int i = lo; i <= hi; i++) v[i] = 1'b1;
      return v;
   endfunction

   task automatic check(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   task automatic check_out(input string req, input int hv, input int er, input int code);
      check(req, "hit_valid", int'(hit_valid), hv);
      check(req, "pattern_err", int'(pattern_err), er);
      check(req, "fine_code", int'(fine_code), code);
   endtask

   // Drive one strobed (or unstrobed) snapshot and check its result two edges later
   task automatic one_shot(input string req, input logic strobe, input logic [TAPS-1:0] pat,
                           input int hv, input int er, input int code);
      @(negedge clk);
      tap_valid = strobe;
      tap_vec   = pat;
      @(negedge clk);
      tap_valid = 1'b0;
      tap_vec   = '0;
      check("R2", "early hit_valid", int'(hit_valid), 0);
      check("R2", "early pattern_err", int'(pattern_err), 0);
      @(negedge clk);
      check_out(req, hv, er, code);
      @(negedge clk);
      check("R2", "single-cycle hit", int'(hit_valid), 0);
      check("R2", "single-cycle err", int'(pattern_err), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check_out("R1", 0, 0, 0);
      rst = 1'b0;
      @(negedge clk);
      check_out("R1", 0, 0, 0);
   endtask

   task automatic t_unstrobed();
      one_shot("R3", 1'b0, run(5, 9), 0, 0, 0);
      one_shot("R3", 1'b0, run(0, 127), 0, 0, 0);
   endtask

   task automatic t_empty();
      one_shot("R4", 1'b1, '0, 0, 0, 0);
   endtask

   task automatic t_clean();
      one_shot("R5", 1'b1, run(5, 9), 1, 0, 14);
      one_shot("R5", 1'b1, run(1, 1), 1, 0, 2);
      one_shot("R5", 1'b1, run(60, 100), 1, 0, 160);
      one_shot("R5", 1'b1, run(33, 34), 1, 0, 67);
   endtask

   task automatic t_far_end();
      one_shot("R6", 1'b1, run(126, 126), 1, 0, 252);
      one_shot("R6", 1'b1, run(1, 126), 1, 0, 127);
   endtask

   task automatic t_overflow();
      one_shot("R7", 1'b1, run(120, 127), 0, 1, 0);
      one_shot("R7", 1'b1, run(127, 127), 0, 1, 0);
   endtask

   task automatic t_overtake();
      one_shot("R8", 1'b1, run(10, 12) | run(20, 25), 0, 1, 0);
      one_shot("R8", 1'b1, run(3, 3) | run(50, 50) | run(90, 91), 0, 1, 0);
   endtask

   task automatic t_entry();
      one_shot("R9", 1'b1, run(0, 30), 0, 1, 0);
      one_shot("R9", 1'b1, run(0, 0) | run(60, 127), 0, 1, 0);
   endtask

   task automatic t_stream();
      logic [TAPS-1:0] pats [4];
      int hv_e [4];
      int er_e [4];
      int cd_e [4];
      pats[0] = run(2, 4);    hv_e[0] = 1; er_e[0] = 0; cd_e[0] = 6;
      pats[1] = run(0, 5);    hv_e[1] = 0; er_e[1] = 1; cd_e[1] = 0;
      pats[2] = run(40, 70);  hv_e[2] = 1; er_e[2] = 0; cd_e[2] = 110;
      pats[3] = run(7, 8);    hv_e[3] = 1; er_e[3] = 0; cd_e[3] = 15;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (k >= 2) check_out("R11", hv_e[k-2], er_e[k-2], cd_e[k-2]);
         if (k < 4) begin
            tap_valid = 1'b1;
            tap_vec   = pats[k];
         end else begin
            tap_valid = 1'b0;
            tap_vec   = '0;
         end
      end
      @(negedge clk);
      check_out("R11", 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_unstrobed();
      t_empty();
      t_clean();
      t_far_end();
      t_overflow();
      t_overtake();
      t_entry();
      t_stream();
      // R10 is covered by every check_out above: code zero and exclusive flags
      finish_run();
   end

   initial begin
      #200000;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

endmodule